// File: doc/BRIEF.md
# Write-All-Then-Verify Memory Device Tester

This engine checks that a range of memory locations really holds data. It is meant for use after the data and address wiring have been shown to work. A start request gives a base address and a length. The engine then writes a distinct, nonzero word to every location in the range, one per cycle, with no read in between. Only after the last write does it read the range back, in the same address order, and compare each returned word against the value that location should hold.

Because every location carries its own value, and all writes finish before the first read, a missing or badly seated device gives itself away. An undriven bus keeps the last written word, and the read of the first location returns that word instead of 1.

Each mismatch is counted, and its address, expected word, actual word and bitwise XOR are kept for inspection. An option ends the test at the first mismatch. Read data is compared a fixed, parameterised number of cycles after each read request, to match the memory's read latency.

Top module: `mem_sweep_tester`

## Requirements
- R1: A start pulse is accepted only while the engine is idle or finished and `prereq_ok_i` is high. `base_i`, `len_i` and `stop_on_err_i` are captured in that cycle. A start with `prereq_ok_i` low, or one given during a run, has no effect: no memory request follows it and the run in progress goes on unchanged.
- R2: In the write phase, location i (i = 0 to len-1) gets one write in consecutive cycles. Its address is (base + i) mod 2^AW and its data is i + 1. Because `len_i` has DW bits, every written word is nonzero and unique within the range.
- R3: No read is issued until all writes of the run are done. The reads then follow at once, one per cycle, at the same addresses in the same order as the writes.
- R4: The word on `mem_rdata_i` exactly RD_LAT cycles after the read request for location i is compared against i + 1.
- R5: Each mismatch loads `err_addr_o`, `err_exp_o`, `err_act_o` and `err_xor_o` with the address, the expected word, the returned word and their XOR, so these outputs show the most recent failure. All four, and the error count, are cleared to zero when a start is accepted.
- R6: `err_cnt_o` goes up by one for each mismatch. It holds at 2^CW-1 rather than wrapping.
- R7: With the stop option captured high, the first mismatch ends the run. No request is issued in later cycles, compares still in flight are dropped, and the error count is 1. With RD_LAT = 2, exactly three reads are issued when the first read fails.
- R8: `done_o` is low from the cycle after an accepted start until the cycle after the last compare, and then stays high until the next accepted start. No request is issued while `done_o` is high. A length of zero makes no memory access, and `done_o` rises RD_LAT + 1 cycles after the start is accepted.
- R9: When the device is absent and every read returns the last value written, every location except the last is reported as a mismatch. The first of these is at the base address, with expected word 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| prereq_ok_i | input | 1 | High when the bus wiring checks have passed |
| stop_on_err_i | input | 1 | End the run at the first mismatch |
| base_i | input | AW | First address of the range |
| len_i | input | DW | Number of locations in the range |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid RD_LAT cycles after a read request |
| done_o | output | 1 | Run finished |
| err_cnt_o | output | CW | Saturating mismatch count |
| err_addr_o | output | AW | Address of the latest mismatch |
| err_exp_o | output | DW | Expected word of the latest mismatch |
| err_act_o | output | DW | Returned word of the latest mismatch |
| err_xor_o | output | DW | Expected XOR returned for the latest mismatch |

## Verification
The compare of an early read overlaps with the issue of later reads. A mismatch, and the decision to stop, can therefore fall in the same cycle as a new read request. The bench provokes this with an absent device, the stop option set and RD_LAT = 2, so the first compare fails while the third read is on the bus. It then judges that exactly three reads appeared in order, that none followed, and that the report names the base address with expected 1 and count 1. A second collision, a mismatch arriving while the count is already at its limit, is provoked with a narrow counter and seven failures in one run.

// File: rtl/mst_pkg.sv
// Shared types for the write-all-then-verify memory tester.
package mst_pkg;
    // Sequencer phases.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WRITE = 3'd1,
        ST_READ  = 3'd2,
        ST_DRAIN = 3'd3,
        ST_DONE  = 3'd4
    } phase_e;
endpackage

// File: rtl/mst_seq.sv
// Sequencer: accepts a start, drives the write sweep and then the read sweep,
// and waits out the read latency before reporting completion.
// Assumes RD_LAT >= 1. An abort (stop option with a mismatch) ends the run at once.
module mst_seq
    import mst_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int RD_LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          prereq_ok_i,
    input  logic          stop_on_err_i,
    input  logic [AW-1:0] base_i,
    input  logic [DW-1:0] len_i,
    input  logic          mismatch_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          rd_issue_o,
    output logic          accept_o,
    output logic          abort_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          stop_o
);
    localparam int DCW = $clog2(RD_LAT + 1);
    localparam logic [DCW-1:0] DRAIN_LAST = DCW'(RD_LAT - 1);

    phase_e        phase;
    logic [DW-1:0] idx;
    logic [DW-1:0] len_q;
    logic [AW-1:0] base_q;
    logic          stop_q;
    logic [DCW-1:0] drain_cnt;
    logic          last;

    // Decode start acceptance, end of sweep and abort.
    always_comb begin
        accept_o = start_i && prereq_ok_i && (phase == ST_IDLE || phase == ST_DONE);
        last     = (idx == len_q - DW'(1));
        abort_o  = mismatch_i && stop_q;
    end

    // Phase, index and captured run settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= ST_IDLE;
            idx       <= '0;
            len_q     <= '0;
            base_q    <= '0;
            stop_q    <= 1'b0;
            drain_cnt <= '0;
        end else begin
            unique case (phase)
                ST_IDLE, ST_DONE: begin
                    if (accept_o) begin
                        base_q    <= base_i;
                        len_q     <= len_i;
                        stop_q    <= stop_on_err_i;
                        idx       <= '0;
                        drain_cnt <= '0;
                        phase     <= (len_i == '0) ? ST_DRAIN : ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (last) begin
                        idx   <= '0;
                        phase <= ST_READ;
                    end else begin
                        idx <= idx + DW'(1);
                    end
                end
                ST_READ: begin
                    if (abort_o) begin
                        phase <= ST_DONE;
                    end else if (last) begin
                        drain_cnt <= '0;
                        phase     <= ST_DRAIN;
                    end else begin
                        idx <= idx + DW'(1);
                    end
                end
                ST_DRAIN: begin
                    if (abort_o || drain_cnt == DRAIN_LAST) begin
                        phase <= ST_DONE;
                    end else begin
                        drain_cnt <= drain_cnt + DCW'(1);
                    end
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    // Memory bus and status drive from the current phase and index.
    always_comb begin
        mem_req_o   = (phase == ST_WRITE) || (phase == ST_READ);
        mem_we_o    = (phase == ST_WRITE);
        mem_addr_o  = base_q + AW'(idx);
        mem_wdata_o = idx + DW'(1);
        rd_issue_o  = (phase == ST_READ);
        busy_o      = (phase == ST_WRITE) || (phase == ST_READ) || (phase == ST_DRAIN);
        done_o      = (phase == ST_DONE);
        stop_o      = stop_q;
    end
endmodule

// File: rtl/mst_delay.sv
// Delay line: carries the address and expected word of each read for DEPTH
// cycles so they meet the returned data. Flush clears every valid bit.
module mst_delay #(
    parameter int W     = 32,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic         vld_i,
    input  logic [W-1:0] dat_i,
    output logic         vld_o,
    output logic [W-1:0] dat_o
);
    logic         vld_q [DEPTH];
    logic [W-1:0] dat_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        // One stage of the delay line.
        always_ff @(posedge clk) begin
            if (!rst_n || flush_i) begin
                vld_q[s] <= 1'b0;
                dat_q[s] <= '0;
            end else if (s == 0) begin
                vld_q[s] <= vld_i;
                dat_q[s] <= dat_i;
            end else begin
                vld_q[s] <= vld_q[(s == 0) ? 0 : s-1];
                dat_q[s] <= dat_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign vld_o = vld_q[DEPTH-1];
    assign dat_o = dat_q[DEPTH-1];
endmodule

// File: rtl/mst_judge.sv
// Comparator and failure record: flags a mismatch when a delayed read
// returns, keeps a saturating count and the details of the latest failure.
// Assumes clear_i pulses on the cycle a run is accepted.
module mst_judge #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          vld_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] exp_i,
    input  logic [DW-1:0] act_i,
    output logic          mismatch_o,
    output logic [CW-1:0] cnt_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] exp_o,
    output logic [DW-1:0] act_o,
    output logic [DW-1:0] xor_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    // Compare the returned word with the expected one.
    assign mismatch_o = vld_i && (act_i != exp_i);

    // Update the count and the failure record.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_o  <= '0;
            addr_o <= '0;
            exp_o  <= '0;
            act_o  <= '0;
            xor_o  <= '0;
        end else if (mismatch_o) begin
            if (cnt_o != CNT_MAX) cnt_o <= cnt_o + CW'(1);
            addr_o <= addr_i;
            exp_o  <= exp_i;
            act_o  <= act_i;
            xor_o  <= exp_i ^ act_i;
        end
    end
endmodule

// File: rtl/mem_sweep_tester.sv
// Top: write-all-then-verify memory tester. Writes i+1 to base+i for the
// whole range, then reads the range back in the same order and compares
// each word RD_LAT cycles after its request. Assumes the bus wiring is good.
module mem_sweep_tester #(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int RD_LAT = 2,
    parameter int CW     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          prereq_ok_i,
    input  logic          stop_on_err_i,
    input  logic [AW-1:0] base_i,
    input  logic [DW-1:0] len_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          done_o,
    output logic [CW-1:0] err_cnt_o,
    output logic [AW-1:0] err_addr_o,
    output logic [DW-1:0] err_exp_o,
    output logic [DW-1:0] err_act_o,
    output logic [DW-1:0] err_xor_o
);
    localparam int PW = AW + DW;

    logic          rd_issue;
    logic          accept;
    logic          abort;
    logic          busy;
    logic          stop_q;
    logic          mismatch;
    logic          pv;
    logic [PW-1:0] pd;

    mst_seq #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT)) i_seq (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .prereq_ok_i(prereq_ok_i), .stop_on_err_i(stop_on_err_i),
        .base_i(base_i), .len_i(len_i), .mismatch_i(mismatch),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .rd_issue_o(rd_issue), .accept_o(accept), .abort_o(abort),
        .busy_o(busy), .done_o(done_o), .stop_o(stop_q)
    );

    mst_delay #(.W(PW), .DEPTH(RD_LAT)) i_delay (
        .clk(clk), .rst_n(rst_n),
        .flush_i(abort || accept),
        .vld_i(rd_issue),
        .dat_i({mem_addr_o, mem_wdata_o}),
        .vld_o(pv), .dat_o(pd)
    );

    mst_judge #(.AW(AW), .DW(DW), .CW(CW)) i_judge (
        .clk(clk), .rst_n(rst_n), .clear_i(accept),
        .vld_i(pv && busy),
        .addr_i(pd[PW-1:DW]), .exp_i(pd[DW-1:0]), .act_i(mem_rdata_i),
        .mismatch_o(mismatch), .cnt_o(err_cnt_o),
        .addr_o(err_addr_o), .exp_o(err_exp_o), .act_o(err_act_o), .xor_o(err_xor_o)
    );
endmodule

// File: rtl/mst_props.sv
// Property checker for mem_sweep_tester, attached by bind below.
module mst_props #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          prereq_ok_i,
    input logic          busy,
    input logic          stop_q,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic          done_o,
    input logic [CW-1:0] err_cnt_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic seen_rd;

    // Track whether the current run has already issued a read.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) seen_rd <= 1'b0;
        else if (mem_req_o && !mem_we_o) seen_rd <= 1'b1;
    end

    AST_PREREQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_i && !prereq_ok_i) |=> !busy); // R1
    AST_WDATA_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (mem_wdata_o != '0)); // R2
    AST_NO_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> !seen_rd); // R3
    AST_CNT_HOLDS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && err_cnt_o == CNT_MAX) |=> (err_cnt_o == CNT_MAX)); // R6
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && $rose(err_cnt_o != '0)) |-> !mem_req_o); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o); // R8
endmodule

bind mem_sweep_tester mst_props #(.AW(AW), .DW(DW), .CW(CW)) i_props (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .prereq_ok_i(prereq_ok_i),
    .busy(busy), .stop_q(stop_q), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .done_o(done_o), .err_cnt_o(err_cnt_o)
);

// File: tb/test_mem_sweep_tester.sv
// Scoreboard bench: a driver task queues the expected bus transactions,
// a monitor pops and compares them as the tester drives the memory bus.
module test_mem_sweep_tester;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int RD_LAT = 2;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          prereq_ok_i = 1'b0;
    logic          stop_on_err_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [DW-1:0] len_i = '0;
    logic          mem_req_o, mem_we_o, done_o;
    logic [AW-1:0] mem_addr_o, err_addr_o;
    logic [DW-1:0] mem_wdata_o, mem_rdata_i, err_exp_o, err_act_o, err_xor_o;
    logic [CW-1:0] err_cnt_o;

    mem_sweep_tester #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT), .CW(CW)) i_mem_sweep_tester (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .prereq_ok_i(prereq_ok_i),
        .stop_on_err_i(stop_on_err_i), .base_i(base_i), .len_i(len_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .done_o(done_o),
        .err_cnt_o(err_cnt_o), .err_addr_o(err_addr_o), .err_exp_o(err_exp_o),
        .err_act_o(err_act_o), .err_xor_o(err_xor_o)
    );

    always #5 clk = ~clk;

    // Memory model: optional absent device (bus keeps last write) and a bit fault.
    logic [DW-1:0] mem [1<<AW];
    logic [DW-1:0] bus_last = '0;
    logic [DW-1:0] p0 = '0, p1 = '0;
    logic          absent = 1'b0;
    logic [AW-1:0] fault_addr = '0;
    logic [DW-1:0] fault_mask = '0;

    always @(posedge clk) begin
        if (mem_req_o && mem_we_o) begin
            mem[mem_addr_o] <= mem_wdata_o;
            bus_last        <= mem_wdata_o;
        end
        if (mem_req_o && !mem_we_o)
            p0 <= absent ? bus_last
                         : (mem[mem_addr_o] ^ ((mem_addr_o == fault_addr) ? fault_mask : '0));
        else
            p0 <= '0;
        p1 <= p0;
    end
    assign mem_rdata_i = p1;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } item_t;
    item_t q[$];

    int n_cmp = 0;
    int n_bad = 0;
    int n_acc = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare every bus transaction with the queued expectation (R2, R3).
    always @(negedge clk) begin
        if (rst_n && mem_req_o) begin
            n_acc++;
            if (q.size() == 0) begin
                chk("R1/R3 unexpected access", {23'd0, mem_we_o, mem_addr_o}, 32'hFFFF_FFFF);
            end else begin
                item_t it;
                it = q.pop_front();
                chk("R3 access kind", {31'd0, mem_we_o}, {31'd0, it.we});
                chk("R2 address", {26'd0, mem_addr_o}, {26'd0, it.addr});
                if (it.we) chk("R2 write data", {24'd0, mem_wdata_o}, {24'd0, it.data});
            end
        end
    end

    // Driver: queue the expected writes and reads, start, wait for done.
    task automatic run(input int base, input int len, input bit stop, input int nreads, input int poke);
        for (int i = 0; i < len; i++) q.push_back('{1'b1, AW'(base + i), DW'(i + 1)});
        for (int i = 0; i < nreads; i++) q.push_back('{1'b0, AW'(base + i), '0});
        @(negedge clk);
        base_i = AW'(base); len_i = DW'(len); stop_on_err_i = stop;
        prereq_ok_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 done low after start", {31'd0, done_o}, 32'd0);
        for (int c = 0; c < poke; c++) @(negedge clk);
        if (poke > 0) begin
            base_i = AW'(base + 32); start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        chk("R3 all queued accesses seen", q.size(), 0);
        q.delete();
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < (1 << AW); a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R8, R6).
        chk("R8 reset done", {31'd0, done_o}, 32'd0);
        chk("R8 reset req", {31'd0, mem_req_o}, 32'd0);
        chk("R6 reset count", {30'd0, err_cnt_o}, 32'd0);

        // R1: start without the prerequisite is ignored.
        start_i = 1'b1; prereq_ok_i = 1'b0; len_i = 8'd5;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        chk("R1 no access without prereq", n_acc, 0);
        chk("R1 no done without prereq", {31'd0, done_o}, 32'd0);

        // R2/R3/R4: good memory.
        run(5, 10, 1'b0, 10, 0);
        chk("R4 good memory count", {30'd0, err_cnt_o}, 32'd0);
        chk("R8 done after run", {31'd0, done_o}, 32'd1);

        // R2: address wraps modulo the address space.
        run(60, 10, 1'b0, 10, 0);
        chk("R2 wrap count", {30'd0, err_cnt_o}, 32'd0);

        // R1: a start during a run is ignored.
        run(0, 20, 1'b0, 20, 7);
        chk("R1 mid-run start ignored", {30'd0, err_cnt_o}, 32'd0);

        // R4/R5: one faulty bit at address 12.
        fault_addr = 6'd12; fault_mask = 8'h10;
        run(10, 8, 1'b0, 8, 0);
        fault_mask = '0;
        chk("R4 fault count", {30'd0, err_cnt_o}, 32'd1);
        chk("R5 fault addr", {26'd0, err_addr_o}, 32'd12);
        chk("R5 fault exp", {24'd0, err_exp_o}, 32'h03);
        chk("R5 fault act", {24'd0, err_act_o}, 32'h13);
        chk("R5 fault xor", {24'd0, err_xor_o}, 32'h10);

        // R9: absent device, all but the last location fail.
        absent = 1'b1;
        run(20, 4, 1'b0, 4, 0);
        chk("R9 absent count", {30'd0, err_cnt_o}, 32'd3);
        chk("R5 latest addr", {26'd0, err_addr_o}, 32'd22);
        chk("R5 latest exp", {24'd0, err_exp_o}, 32'd3);
        chk("R5 latest act", {24'd0, err_act_o}, 32'd4);
        chk("R5 latest xor", {24'd0, err_xor_o}, 32'd7);

        // R7: stop option, the abort meets the third read.
        run(40, 8, 1'b1, 3, 0);
        repeat (4) @(negedge clk);
        chk("R7 stop count", {30'd0, err_cnt_o}, 32'd1);
        chk("R7 stop addr", {26'd0, err_addr_o}, 32'd40);
        chk("R7 stop exp", {24'd0, err_exp_o}, 32'd1);
        chk("R7 stop act", {24'd0, err_act_o}, 32'd8);
        chk("R7 stop xor", {24'd0, err_xor_o}, 32'd9);

        // R6: seven failures saturate a two-bit counter.
        run(0, 8, 1'b0, 8, 0);
        chk("R6 saturated count", {30'd0, err_cnt_o}, 32'd3);
        chk("R5 sat latest addr", {26'd0, err_addr_o}, 32'd6);
        chk("R5 sat latest xor", {24'd0, err_xor_o}, 32'h0F);
        absent = 1'b0;

        // R5: a new start clears the record.
        run(1, 3, 1'b0, 3, 0);
        chk("R5 cleared count", {30'd0, err_cnt_o}, 32'd0);
        chk("R5 cleared addr", {26'd0, err_addr_o}, 32'd0);
        chk("R5 cleared xor", {24'd0, err_xor_o}, 32'd0);

        // R8: zero length, no access, done after RD_LAT+1 cycles.
        begin
            int acc0;
            acc0 = n_acc;
            base_i = 6'd3; len_i = 8'd0; start_i = 1'b1; prereq_ok_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk("R8 len0 done low", {31'd0, done_o}, 32'd0);
            @(negedge clk);
            chk("R8 len0 still low", {31'd0, done_o}, 32'd0);
            @(negedge clk);
            chk("R8 len0 done high", {31'd0, done_o}, 32'd1);
            chk("R8 len0 no access", n_acc - acc0, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule